// File: doc/BRIEF.md
# Integer Adder-Subtractor with Condition Flags

This unit performs add, add-with-carry, subtract and subtract-with-borrow on two operands of a configurable width using one binary adder. For subtraction the second operand is bitwise inverted and the adder's carry input is driven so that no separate subtractor is needed. The carry flag holds a true carry after an add and a borrow after a subtract. On a subtract the carry out of the most significant bit is inverted, and so is the stored carry fed back in for subtract-with-borrow.

Each accepted operation produces a result and four flags: carry/borrow, signed overflow, negative and zero. Multi-word arithmetic is done by issuing the lowest word with a plain add or subtract. Each higher word then uses the chained variant, with the previous carry flag on `carry_i`. The result and the flags are registered on the rising clock edge when `valid_i` is high, and they hold otherwise.

Top module: `addsub_unit`

## Requirements
- R1: Operation code 2'b00 (add) yields result = (a + b) mod 2^W, and carry = 1 exactly when the unsigned sum exceeds 2^W - 1 (8 + 8 at W=4 gives 0000 with carry 1).
- R2: Operation code 2'b01 (add-with-carry) yields result = (a + b + carry_i) mod 2^W, and carry = 1 exactly when that unsigned sum exceeds 2^W - 1.
- R3: Operation code 2'b10 (subtract) yields result = (a - b) mod 2^W, and carry = 1 (borrow) exactly when a < b as unsigned values; 5 - 0 and 15 - 1 at W=4 give carry 0.
- R4: Operation code 2'b11 (subtract-with-borrow) yields result = (a - b - carry_i) mod 2^W, and carry = 1 exactly when a < b + carry_i as unsigned values.
- R5: Overflow is 1 exactly when the signed two's-complement value of the true sum or difference, carry_i included, lies outside the signed W-bit range (4 + 4 at W=4 sets overflow and clears carry). This matches the sign-bit rule: operands of equal effective sign whose result sign differs.
- R6: Negative equals bit W-1 of the result, and zero is 1 exactly when every result bit is 0.
- R7: A result and its flags appear on the outputs with valid_o = 1 one cycle after valid_i is sampled high. When valid_i is low, the outputs hold and valid_o is 0 in the next cycle.
- R8: While rst_ni is low, the result, all four flags and valid_o are 0, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Accept the operands and operation this cycle |
| op_i | input | 2 | 00 add, 01 add-with-carry, 10 subtract, 11 subtract-with-borrow |
| a_i | input | W | First operand |
| b_i | input | W | Second operand |
| carry_i | input | 1 | Stored carry/borrow flag used by the chained operations |
| result_o | output | W | Registered result |
| carry_o | output | 1 | Carry on add, borrow on subtract |
| overflow_o | output | 1 | Signed overflow |
| negative_o | output | 1 | Result sign bit |
| zero_o | output | 1 | Result is all zeros |
| valid_o | output | 1 | Outputs were updated by the previous cycle's operation |

## Verification
The bench builds the unit with W = 4. At that width all 256 operand pairs, all four operations and both carry-in values can be driven, which is 2048 operations, and each is compared against a reference computed in wider integer arithmetic. Exhaustive coverage at this width includes every corner where the flags change meaning: the all-zero and the single-high-bit operands, the zero-minus-anything borrows, and subtracting zero, which raises the raw adder carry but no borrow. The ripple structure is the same at every width, so these corners carry over to wider settings.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_ADC = 2'b01,
    OP_SUB = 2'b10,
    OP_SBB = 2'b11
  } op_e;

  typedef struct packed {
    logic c;
    logic v;
    logic n;
    logic z;
  } flags_t;
endpackage

// File: rtl/addsub_operand_prep.sv
module addsub_operand_prep
  import addsub_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [1:0]   op_i,
  input  logic [W-1:0] b_i,
  input  logic         carry_i,
  output logic [W-1:0] b_o,
  output logic         cin_o,
  output logic         sub_o
);
  op_e op;
  assign op    = op_e'(op_i);
  assign sub_o = op_i[1];
  assign b_o   = sub_o ? ~b_i : b_i;

  always_comb begin
    unique case (op)
      OP_ADD:  cin_o = 1'b0;
      OP_ADC:  cin_o = carry_i;
      OP_SUB:  cin_o = 1'b1;
      OP_SBB:  cin_o = ~carry_i; // stored flag is a borrow
      default: cin_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/addsub_ripple.sv
module addsub_ripple #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         c_msb_o,
  output logic         cout_o
);
  logic [W:0] c;
  assign c[0] = cin_i;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum_o[i] = a_i[i] ^ b_i[i] ^ c[i];
    assign c[i+1]   = (a_i[i] & b_i[i]) | (c[i] & (a_i[i] ^ b_i[i]));
  end

  assign c_msb_o = c[W-1];
  assign cout_o  = c[W];
endmodule

// File: rtl/addsub_flags.sv
module addsub_flags
  import addsub_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] sum_i,
  input  logic         c_msb_i,
  input  logic         cout_i,
  input  logic         sub_i,
  output flags_t       flags_o
);
  assign flags_o.c = cout_i ^ sub_i;   // raw carry 1 on subtract means no borrow
  assign flags_o.v = c_msb_i ^ cout_i;
  assign flags_o.n = sum_i[W-1];
  assign flags_o.z = ~|sum_i;
endmodule

// File: rtl/addsub_unit.sv
module addsub_unit
  import addsub_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [1:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         carry_i,
  output logic [W-1:0] result_o,
  output logic         carry_o,
  output logic         overflow_o,
  output logic         negative_o,
  output logic         zero_o,
  output logic         valid_o
);
  localparam int MSB = W - 1;

  logic [W-1:0] b_eff, sum;
  logic         cin, sub, c_msb, cout;
  flags_t       flags_d, flags_q;

  addsub_operand_prep #(.W(W)) u_prep (
    .op_i(op_i), .b_i(b_i), .carry_i(carry_i),
    .b_o(b_eff), .cin_o(cin), .sub_o(sub)
  );

  addsub_ripple #(.W(W)) u_add (
    .a_i(a_i), .b_i(b_eff), .cin_i(cin),
    .sum_o(sum), .c_msb_o(c_msb), .cout_o(cout)
  );

  addsub_flags #(.W(W)) u_flags (
    .sum_i(sum), .c_msb_i(c_msb), .cout_i(cout), .sub_i(sub),
    .flags_o(flags_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      flags_q  <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o <= sum;
        flags_q  <= flags_d;
      end
    end
  end

  assign carry_o    = flags_q.c;
  assign overflow_o = flags_q.v;
  assign negative_o = flags_q.n;
  assign zero_o     = flags_q.z;

  // R1
  add_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(op_i) == 2'b00) |->
      ({carry_o, result_o} == ({1'b0, $past(a_i)} + {1'b0, $past(b_i)})));

  // R3
  sub_borrow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(op_i) == 2'b10) |->
      (carry_o == ($past(a_i) < $past(b_i)) && result_o == W'($past(a_i) - $past(b_i))));

  // R5
  ovf_sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (overflow_o ==
      (($past(a_i[MSB]) == ($past(op_i[1]) ^ $past(b_i[MSB]))) &&
       (result_o[MSB] != ($past(op_i[1]) ^ $past(b_i[MSB]))))));

  // R6
  zero_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (zero_o == (result_o == '0)));

  // R7
  accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  // R7
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(result_o) && $stable(carry_o) &&
                  $stable(overflow_o) && $stable(zero_o)));
endmodule

// File: tb/sim_addsub_unit.sv
`timescale 1ns/1ps
module sim_addsub_unit;
  localparam int W = 4;
  localparam int N = 1 << W;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         valid_i;
  logic [1:0]   op_i;
  logic [W-1:0] a_i, b_i;
  logic         carry_i;
  logic [W-1:0] result_o;
  logic         carry_o, overflow_o, negative_o, zero_o, valid_o;

  always #2 clk = ~clk;

  addsub_unit #(.W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .op_i(op_i),
    .a_i(a_i), .b_i(b_i), .carry_i(carry_i),
    .result_o(result_o), .carry_o(carry_o), .overflow_o(overflow_o),
    .negative_o(negative_o), .zero_o(zero_o), .valid_o(valid_o)
  );

  typedef struct {
    int res;
    bit c, v, n, z;
    int op;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic exp_t model(input int op, input int a, input int b, input int ci);
    exp_t e;
    int sa, sb, u, s, k;
    sa = (a >= N/2) ? a - N : a;
    sb = (b >= N/2) ? b - N : b;
    k  = (op == 1 || op == 3) ? ci : 0;
    if (op < 2) begin
      u = a + b + k;  s = sa + sb + k;  e.c = (u >= N);
    end else begin
      u = a - b - k;  s = sa - sb - k;  e.c = (u < 0);
    end
    e.res = u & (N - 1);
    e.v   = (s < -(N/2)) || (s > N/2 - 1);
    e.n   = (e.res >= N/2);
    e.z   = (e.res == 0);
    e.op  = op;
    return e;
  endfunction

  function automatic string op_req(input int op);
    case (op)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      default: return "R4";
    endcase
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      if (q.size() == 0) begin
        chk(1'b0, "R7", "valid_o without pending op", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(int'(result_o) == e.res, op_req(e.op), "result", int'(result_o), e.res);
        chk(carry_o == e.c, op_req(e.op), "carry", int'(carry_o), int'(e.c));
        chk(overflow_o == e.v, "R5", "overflow", int'(overflow_o), int'(e.v));
        chk(negative_o == e.n, "R6", "negative", int'(negative_o), int'(e.n));
        chk(zero_o == e.z, "R6", "zero", int'(zero_o), int'(e.z));
      end
    end
  end

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    checks++;
    errors++;
    $display("FAIL R7 watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    logic [W-1:0] held;
    rst_n   = 1'b0;
    valid_i = 1'b0;
    op_i    = '0;
    a_i     = '0;
    b_i     = '0;
    carry_i = 1'b0;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk({result_o, carry_o, overflow_o, negative_o, zero_o, valid_o} == '0,
        "R8", "outputs in reset", int'(result_o), 0);
    rst_n = 1'b1;

    // driver: every op, operand pair and carry-in
    for (int op = 0; op < 4; op++)
      for (int a = 0; a < N; a++)
        for (int b = 0; b < N; b++)
          for (int ci = 0; ci < 2; ci++) begin
            @(negedge clk);
            valid_i = 1'b1;
            op_i    = 2'(op);
            a_i     = W'(a);
            b_i     = W'(b);
            carry_i = ci[0];
            q.push_back(model(op, a, b, ci));
          end
    @(negedge clk);
    valid_i = 1'b0;
    @(negedge clk);
    // R7 everything consumed
    chk(q.size() == 0, "R7", "pending ops", q.size(), 0);

    // R7 hold while idle, with changing inputs
    held = result_o;
    a_i  = W'(3);
    b_i  = W'(9);
    op_i = 2'b01;
    repeat (3) @(negedge clk);
    chk(result_o == held, "R7", "held result", int'(result_o), int'(held));
    chk(valid_o == 1'b0, "R7", "valid_o idle", int'(valid_o), 0);

    // R8 asynchronous reset mid-run
    @(negedge clk);
    valid_i = 1'b1;
    a_i     = W'(7);
    b_i     = W'(1);
    op_i    = 2'b00;
    q.push_back(model(0, 7, 1, 0));
    @(negedge clk);
    valid_i = 1'b0;
    #0.5;
    rst_n = 1'b0;
    #0.5;
    chk({result_o, carry_o, overflow_o, negative_o, zero_o, valid_o} == '0,
        "R8", "async clear", int'(result_o), 0);
    q.delete();
    @(negedge clk);
    summary();
  end
endmodule